// File: doc/BRIEF.md
# Fractional Timer Clock-Enable Generator

This block derives a timer clock-enable stream averaging 2.4576 MHz from an 8 MHz system clock, with no PLL and no clock division. The two rates stand in the exact ratio 625:192. The block spaces successive enable pulses either 3 or 4 system clocks apart. A signed error accumulator chooses each spacing, so every 625 system clocks carry exactly 192 pulses and the timing error never builds up.

Downstream timer logic runs on the system clock and advances only in cycles where `tick_o` is high. `span_o` reports the length of the interval now in progress, for debug. A synchronous clear, `clr_i`, restarts the sequence exactly as a reset does, without touching the asynchronous reset.

Top module: `frac_ce_gen`

## Requirements
- R1: After reset, `tick_o` is low and `span_o` reads 3. The first pulse is high in the third clock cycle after reset release, counting the cycle in which reset is released.
- R2: `tick_o` is high for exactly one clock cycle per pulse and is never high in two consecutive cycles.
- R3: The distance from one pulse to the next is always either 3 or 4 clock cycles.
- R4: An accumulator is cleared to 0 by reset. At the end of each interval, if it is negative the next interval is 4 cycles long and 143 is added; otherwise the next interval is 3 cycles long and 49 is subtracted. It stays within -49..142. From reset, the first sixteen intervals are therefore 3,4,3,3,4,3,3,3,4,3,3,3,4,3,3,3.
- R5: Any 625 consecutive clock cycles contain exactly 192 pulses.
- R6: The pulse pattern repeats with a period of exactly 625 cycles.
- R7: `span_o` gives the length of the current interval: 3 or 4 in binary. It holds steady from the cycle after one pulse up to and including the next pulse, and at each pulse it equals the distance from the previous pulse.
- R8: While `clr_i` is high at a rising edge, the sequence is restarted. `tick_o` is low in every cycle in which `clr_i` is high. After `clr_i` falls, the timing is the same as after reset release (R1, R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (8 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous restart of the pulse sequence |
| tick_o | output | 1 | One-cycle timer clock-enable pulse |
| span_o | output | 3 | Length in cycles of the interval in progress (debug) |

## Verification
The main function is tried under three input patterns. The first is a clean start from reset, compared interval by interval against the first sixteen spacings the accumulator rule predicts. This separates a wrong sign decision or constant from a merely plausible 3/4 mix. The second is a free run of three full periods, scanned at every window offset for the 192-in-625 count and for exact 625-cycle periodicity; this exposes drift that a short sequence hides. The third is a restart by `clr_i` and a reset asserted in mid-interval. These show that the sequence restarts in the same phase and that no pulse escapes while the clear is held.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;

  // Default ratio: 625 input clocks carry 192 enables.
  localparam int unsigned DEF_SHORT_LEN = 3;    // cycles in a short interval
  localparam int unsigned DEF_SHORT_CNT = 143;  // short intervals per period
  localparam int unsigned DEF_LONG_CNT  = 49;   // long intervals per period

  // Signed width holding -long_cnt .. short_cnt-1
  function automatic int unsigned sum_width(input int unsigned short_cnt,
                                             input int unsigned long_cnt);
    int unsigned mag;
    mag = (short_cnt > long_cnt) ? short_cnt : long_cnt;
    return $clog2(mag + 1) + 1;
  endfunction

endpackage

// File: rtl/frac_ce_steer.sv
module frac_ce_steer
  import frac_ce_pkg::*;
#(
  parameter int unsigned SHORT_CNT = DEF_SHORT_CNT,
  parameter int unsigned LONG_CNT  = DEF_LONG_CNT,
  localparam int unsigned SUM_W    = sum_width(SHORT_CNT, LONG_CNT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    adv_i,
  output logic                    long_o,
  output logic signed [SUM_W-1:0] sum_o
);

  localparam logic signed [SUM_W-1:0] ADD_C = SUM_W'(SHORT_CNT);
  localparam logic signed [SUM_W-1:0] SUB_C = SUM_W'(LONG_CNT);

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_d;
  logic                    sum_en;

  // Negative error: the stream runs ahead, so stretch the next interval.
  assign long_o = sum_q[SUM_W-1];

  assign sum_en = clr_i | adv_i;

  always_comb begin
    if (clr_i) begin
      sum_d = '0;
    end else if (long_o) begin
      sum_d = sum_q + ADD_C;
    end else begin
      sum_d = sum_q - SUB_C;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/frac_ce_interval.sv
module frac_ce_interval
  import frac_ce_pkg::*;
#(
  parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
  localparam int unsigned CNT_W    = $clog2(SHORT_LEN + 1),
  localparam int unsigned SPAN_W   = $clog2(SHORT_LEN + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              long_i,
  output logic              end_o,
  output logic [SPAN_W-1:0] span_o
);

  localparam logic [CNT_W-1:0]  LAST_SHORT = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0]  LAST_LONG  = CNT_W'(SHORT_LEN);
  localparam logic [SPAN_W-1:0] SPAN_SHORT = SPAN_W'(SHORT_LEN);
  localparam logic [SPAN_W-1:0] SPAN_LONG  = SPAN_W'(SHORT_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             last_w;

  assign last_w = (cnt_q == (long_i ? LAST_LONG : LAST_SHORT));

  always_comb begin
    if (clr_i || last_w) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign end_o  = last_w & ~clr_i;
  assign span_o = long_i ? SPAN_LONG : SPAN_SHORT;

endmodule

// File: rtl/frac_ce_gen.sv
module frac_ce_gen
  import frac_ce_pkg::*;
#(
  parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
  parameter int unsigned SHORT_CNT = DEF_SHORT_CNT,
  parameter int unsigned LONG_CNT  = DEF_LONG_CNT,
  localparam int unsigned SPAN_W   = $clog2(SHORT_LEN + 2),
  localparam int unsigned SUM_W    = sum_width(SHORT_CNT, LONG_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic              tick_o,
  output logic [SPAN_W-1:0] span_o
);

  logic                    long_w;
  logic                    end_w;
  logic signed [SUM_W-1:0] sum_w;

  frac_ce_steer #(
    .SHORT_CNT (SHORT_CNT),
    .LONG_CNT  (LONG_CNT)
  ) u_steer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .adv_i  (end_w),
    .long_o (long_w),
    .sum_o  (sum_w)
  );

  frac_ce_interval #(
    .SHORT_LEN (SHORT_LEN)
  ) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .long_i (long_w),
    .end_o  (end_w),
    .span_o (span_o)
  );

  assign tick_o = end_w;

endmodule

// File: rtl/frac_ce_chk.sv
module frac_ce_chk
  import frac_ce_pkg::*;
#(
  parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
  parameter int unsigned SHORT_CNT = DEF_SHORT_CNT,
  parameter int unsigned LONG_CNT  = DEF_LONG_CNT,
  localparam int unsigned SPAN_W   = $clog2(SHORT_LEN + 2),
  localparam int unsigned SUM_W    = sum_width(SHORT_CNT, LONG_CNT),
  localparam int unsigned PERIOD   = SHORT_LEN * SHORT_CNT + (SHORT_LEN + 1) * LONG_CNT,
  localparam int unsigned PULSES   = SHORT_CNT + LONG_CNT,
  localparam int unsigned PH_W     = $clog2(PERIOD + 1),
  localparam int unsigned GAP_W    = $clog2(SHORT_LEN + 3)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    tick_o,
  input  logic [SPAN_W-1:0]       span_o,
  input  logic signed [SUM_W-1:0] sum_i
);

  logic [GAP_W-1:0] gap_q;
  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      phase_q <= '0;
      pcnt_q  <= '0;
    end else if (clr_i) begin
      gap_q   <= '0;
      phase_q <= '0;
      pcnt_q  <= '0;
    end else begin
      if (tick_o) begin
        gap_q <= '0;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      if (phase_q == PH_W'(PERIOD - 1)) begin
        phase_q <= '0;
        pcnt_q  <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
        pcnt_q  <= pcnt_q + PH_W'(tick_o);
      end
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_gap_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q >= GAP_W'(SHORT_LEN - 1)));

  assert_gap_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_W'(SHORT_LEN));

  assert_sum_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sum_i) >= -int'(LONG_CNT)) && (int'(sum_i) < int'(SHORT_CNT)));

  assert_sum_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && sum_i < 0) |=> (int'(sum_i) == int'($past(sum_i)) + int'(SHORT_CNT)));

  assert_sum_sub_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && sum_i >= 0) |=> (int'(sum_i) == int'($past(sum_i)) - int'(LONG_CNT)));

  assert_window_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_q == PH_W'(PERIOD - 1)) |-> ((pcnt_q + PH_W'(tick_o)) == PH_W'(PULSES)));

  assert_span_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !clr_i) |=> $stable(span_o));

  assert_span_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (span_o == SPAN_W'(gap_q + 1'b1)));

  assert_clr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !tick_o);

endmodule

bind frac_ce_gen frac_ce_chk #(
  .SHORT_LEN (SHORT_LEN),
  .SHORT_CNT (SHORT_CNT),
  .LONG_CNT  (LONG_CNT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .tick_o (tick_o),
  .span_o (span_o),
  .sum_i  (sum_w)
);

// File: tb/frac_ce_gen_tb.sv
module frac_ce_gen_tb;

  localparam int NSAMP = 1875;
  localparam int NGAPS = 16;
  localparam int GAPS [NGAPS] = '{3, 4, 3, 3, 4, 3, 3, 3, 4, 3, 3, 3, 4, 3, 3, 3};

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic       tick;
  logic [2:0] span;

  int  n_run;
  int  n_fail;
  bit  done;
  bit  hist [NSAMP];
  int  sp   [NSAMP];

  frac_ce_gen u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .clr_i  (clr),
    .tick_o (tick),
    .span_o (span)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 16);
  endtask

  task automatic check_restart(input string req);
    int n;
    @(negedge clk);
    check(tick == 1'b0, {req, " no pulse in first cycle after release"}, tick, 0);
    @(negedge clk);
    check(tick == 1'b1, {req, " first pulse in third cycle"}, tick, 1);
    check(span == 3'd3, {req, " first interval span"}, span, 3);
    wait_tick(n);
    check(n == 4, {req, " second interval"}, n, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int last;
    int cnt;
    int bad;
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    clr    = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick low in reset", tick, 0);
    check(span == 3'd3, "R1 span in reset", span, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R1 no pulse right after release", tick, 0);
    @(negedge clk);
    check(tick == 1'b1, "R1 first pulse in third cycle", tick, 1);
    check(span == 3'd3, "R7 span of first interval", span, 3);

    // R4 / R7: interval table walked from reset
    for (int i = 1; i < NGAPS; i++) begin
      wait_tick(n);
      check(n == GAPS[i], $sformatf("R4 interval %0d", i), n, GAPS[i]);
      check(int'(span) == GAPS[i], $sformatf("R7 span at pulse %0d", i), span, GAPS[i]);
    end

    // Free run over three periods
    for (int i = 0; i < NSAMP; i++) begin
      @(negedge clk);
      hist[i] = tick;
      sp[i]   = int'(span);
    end

    // R2: never two adjacent pulses
    bad = 0;
    for (int i = 0; i < NSAMP - 1; i++) if (hist[i] && hist[i+1]) bad++;
    check(bad == 0, "R2 adjacent pulses", bad, 0);

    // R3 and R7: gap bounds and span agreement
    bad  = 0;
    cnt  = 0;
    last = -1;
    for (int i = 0; i < NSAMP; i++) begin
      if (i > 0 && !hist[i-1] && sp[i] != sp[i-1]) cnt++;
      if (hist[i]) begin
        if (last >= 0) begin
          if ((i - last) < 3 || (i - last) > 4) bad++;
          if ((i - last) != sp[i]) cnt++;
        end
        last = i;
      end
    end
    check(bad == 0, "R3 gaps outside 3..4", bad, 0);
    check(cnt == 0, "R7 span mismatches", cnt, 0);

    // R5: every 625-cycle window
    cnt = 0;
    for (int i = 0; i < 625; i++) cnt += int'(hist[i]);
    check(cnt == 192, "R5 window at offset 0", cnt, 192);
    for (int s = 1; s + 625 <= NSAMP; s++) begin
      cnt = cnt - int'(hist[s-1]) + int'(hist[s+624]);
      check(cnt == 192, $sformatf("R5 window at offset %0d", s), cnt, 192);
    end

    // R6: period of 625
    bad = 0;
    for (int i = 0; i + 625 < NSAMP; i++) if (hist[i] != hist[i+625]) bad++;
    check(bad == 0, "R6 pattern mismatches at shift 625", bad, 0);

    // R8: clear held mid-run
    repeat (2) @(negedge clk);
    clr = 1'b1;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tick) bad++;
      check(span == 3'd3, "R8 span during clear", span, 3);
    end
    check(bad == 0, "R8 pulses during clear", bad, 0);
    clr = 1'b0;
    check_restart("R8");

    // R1: reset asserted mid-interval
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R1 tick low in mid-run reset", tick, 0);
    check(span == 3'd3, "R1 span in mid-run reset", span, 3);
    rst_n = 1'b1;
    check_restart("R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule